// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits between the decode and execute stages of a five-stage in-order pipeline that has full operand forwarding. Forwarding covers every dependence except one: a load produces its value only at the end of the memory stage, so an instruction that reads the loaded register in the very next slot cannot get it in time. The block spots that pairing and holds the dependent instruction in decode for one extra cycle. It does this by gating the program counter and the decode pipeline register, and by turning the control word entering the execute stage into a no-op.

The checks are purely combinational. They take the memory-read flag and destination register of the instruction now in execute, and the opcode and two source register fields of the instruction now in decode. Only the decode-stage source fields that the instruction really reads are compared. The second field is a source only for register-format, store and the two equality branches. Every other dependence proceeds without delay.

Top module: `lu_stall_unit`

## Requirements
- R1: A hazard is flagged when `ex_is_load`=1, `ex_dst`≠0 and `ex_dst` equals `dec_rs`, for any `dec_op`.
- R2: A match between `ex_dst` and `dec_rt` flags a hazard only when `dec_op` is 0 (register format), 4 or 5 (equality branches) or 43 (store). For any other opcode, such as 35 (load) or 2 (jump), it does not.
- R3: With `ex_is_load`=0 no hazard is flagged, whatever the register fields hold.
- R4: A load whose destination is register 0 never causes a hazard.
- R5: On a hazard `pc_en`=0, `dec_en`=0 and `bubble`=1. Otherwise `pc_en`=1, `dec_en`=1 and `bubble`=0.
- R6: Control word bits are bit 0 register write, bit 1 memory-to-register, bit 2 memory write, bit 3 memory read, bit 4 branch, bit 5 ALU source, bit 6 register destination, and bits 8:7 ALU op. With `bubble`=1, `ex_ctrl` equals `dec_ctrl` with bits 0, 2, 3 and 4 cleared. With `bubble`=0, `ex_ctrl` equals `dec_ctrl`.
- R7: In a pipeline driven by the block, a load followed at once by an instruction that reads the loaded register costs exactly one cycle. The dependent instruction and every later one retire one cycle later, and each instruction still retires exactly once.
- R8: A load followed by an instruction that does not read its destination, or whose reader is two slots behind it, costs no cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_load | input | 1 | Execute-stage instruction reads memory |
| ex_dst | input | 5 | Execute-stage load destination register |
| dec_op | input | 6 | Decode-stage opcode |
| dec_rs | input | 5 | Decode-stage first source register field |
| dec_rt | input | 5 | Decode-stage second register field |
| dec_ctrl | input | 9 | Control word produced in decode |
| pc_en | output | 1 | Program counter write enable |
| dec_en | output | 1 | Decode pipeline register write enable |
| bubble | output | 1 | A no-op is sent into execute this cycle |
| ex_ctrl | output | 9 | Control word written into the execute pipeline register |

## Verification
The hardest situation to reach from the ports is the timing effect. The stall must last exactly one cycle, must release by itself once the bubble reaches execute, and must neither drop nor duplicate the held instruction. The bench therefore wraps the block in a small model with a program counter, four pipeline registers and a program store, runs short instruction sequences through it, and compares the retire edge of each tagged instruction with the figures worked out by hand. Direct port drives cover the opcode classes and the register-0 case.

// File: rtl/lu_pkg.sv
package lu_pkg;
  parameter int REG_AW = 5;
  parameter int OP_W   = 6;
  parameter int CTRL_W = 9;

  localparam logic [OP_W-1:0] OPC_RFMT  = 6'd0;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OPC_STORE = 6'd43;

  localparam int CB_REGWR = 0;
  localparam int CB_MEMWR = 2;
  localparam int CB_MEMRD = 3;
  localparam int CB_BRANCH = 4;

  localparam logic [CTRL_W-1:0] BUBBLE_CLR =
    CTRL_W'((1 << CB_REGWR) | (1 << CB_MEMWR) | (1 << CB_MEMRD) | (1 << CB_BRANCH));
endpackage

// File: rtl/lu_src_decode.sv
module lu_src_decode
  import lu_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] op,
  output logic           rt_is_src
);
  always_comb begin
    unique case (op)
      OPC_RFMT, OPC_BEQ, OPC_BNE, OPC_STORE: rt_is_src = 1'b1;
      default:                               rt_is_src = 1'b0;
    endcase
  end
endmodule

// File: rtl/lu_match.sv
module lu_match #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                    ld_valid,
  input  logic [AW-1:0]           ld_dst,
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [NSRC-1:0]         src_used,
  output logic                    hazard
);
  logic           dst_live;
  logic [NSRC-1:0] hit;

  assign dst_live = ld_valid && (ld_dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_used[g] && (src[g] == ld_dst);
  end

  assign hazard = dst_live && (|hit);
endmodule

// File: rtl/lu_ctrl_gate.sv
module lu_ctrl_gate #(
  parameter int              CW   = 9,
  parameter logic [CW-1:0]   CLR  = '0
) (
  input  logic          kill,
  input  logic [CW-1:0] ctrl_i,
  output logic [CW-1:0] ctrl_o
);
  for (genvar b = 0; b < CW; b++) begin : g_bit
    if (CLR[b]) begin : g_clr
      assign ctrl_o[b] = ctrl_i[b] & ~kill;
    end else begin : g_pass
      assign ctrl_o[b] = ctrl_i[b];
    end
  end
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit
  import lu_pkg::*;
#(
  parameter int AW  = REG_AW,
  parameter int OPW = OP_W,
  parameter int CW  = CTRL_W
) (
  input  logic           ex_is_load,
  input  logic [AW-1:0]  ex_dst,
  input  logic [OPW-1:0] dec_op,
  input  logic [AW-1:0]  dec_rs,
  input  logic [AW-1:0]  dec_rt,
  input  logic [CW-1:0]  dec_ctrl,
  output logic           pc_en,
  output logic           dec_en,
  output logic           bubble,
  output logic [CW-1:0]  ex_ctrl
);
  localparam int NSRC = 2;

  logic                   rt_src;
  logic [NSRC-1:0][AW-1:0] srcs;
  logic [NSRC-1:0]        used;
  logic                   hz;

  lu_src_decode #(.OPW(OPW)) u_dec (
    .op        (dec_op),
    .rt_is_src (rt_src)
  );

  assign srcs = {dec_rt, dec_rs};
  assign used = {rt_src, 1'b1};

  lu_match #(.AW(AW), .NSRC(NSRC)) u_match (
    .ld_valid (ex_is_load),
    .ld_dst   (ex_dst),
    .src      (srcs),
    .src_used (used),
    .hazard   (hz)
  );

  assign pc_en  = ~hz;
  assign dec_en = ~hz;
  assign bubble = hz;

  lu_ctrl_gate #(.CW(CW), .CLR(CW'(BUBBLE_CLR))) u_gate (
    .kill   (hz),
    .ctrl_i (dec_ctrl),
    .ctrl_o (ex_ctrl)
  );

  always_comb begin
    p_no_load_no_stall_r3: assert (ex_is_load || pc_en);
    p_zero_dst_no_stall_r4: assert ((ex_dst != '0) || !bubble);
    p_stall_has_rs_or_rt_r1: assert (!bubble || (dec_rs == ex_dst) || (dec_rt == ex_dst));
    p_bubble_clears_ctrl_r6: assert (!bubble || ((ex_ctrl & CW'(BUBBLE_CLR)) == '0));
    p_ctrl_pass_r6: assert (bubble || (ex_ctrl == dec_ctrl));
    p_enables_agree_r5: assert ((pc_en == dec_en) && (pc_en != bubble));
  end
endmodule

// File: tb/sim_lu_stall_unit.sv
module sim_lu_stall_unit;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  typedef struct packed {
    logic       v;
    logic       ld;
    logic [5:0] op;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [3:0] tag;
  } ins_t;

  // unit-mode drives
  logic       unit_mode;
  logic       u_ld;
  logic [4:0] u_dst, u_rs, u_rt;
  logic [5:0] u_op;
  logic [8:0] u_ctrl;

  // pipeline model
  ins_t       prog [0:7];
  logic [3:0] pc;
  ins_t       ifid, idex, exmem, memwb;
  int         edge_n;
  int         ret_edge [0:7];
  int         ret_cnt  [0:7];

  logic       ex_is_load, pc_en, dec_en, bubble;
  logic [4:0] ex_dst, dec_rs, dec_rt;
  logic [5:0] dec_op;
  logic [8:0] dec_ctrl, ex_ctrl;

  assign ex_is_load = unit_mode ? u_ld  : (idex.v & idex.ld);
  assign ex_dst     = unit_mode ? u_dst : idex.rt;
  assign dec_op     = unit_mode ? u_op  : ifid.op;
  assign dec_rs     = unit_mode ? u_rs  : ifid.rs;
  assign dec_rt     = unit_mode ? u_rt  : ifid.rt;
  assign dec_ctrl   = unit_mode ? u_ctrl : 9'h1FF;

  lu_stall_unit u0 (
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .dec_op     (dec_op),
    .dec_rs     (dec_rs),
    .dec_rt     (dec_rt),
    .dec_ctrl   (dec_ctrl),
    .pc_en      (pc_en),
    .dec_en     (dec_en),
    .bubble     (bubble),
    .ex_ctrl    (ex_ctrl)
  );

  ins_t fetched;
  assign fetched = (pc < 4'd8) ? prog[pc[2:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      ifid   <= '0;
      idex   <= '0;
      exmem  <= '0;
      memwb  <= '0;
      edge_n <= 0;
      for (int i = 0; i < 8; i++) begin
        ret_edge[i] <= -1;
        ret_cnt[i]  <= 0;
      end
    end else begin
      edge_n <= edge_n + 1;
      if (pc_en) pc <= pc + 4'd1;
      if (dec_en) ifid <= fetched;
      idex  <= bubble ? '0 : ifid;
      exmem <= idex;
      memwb <= exmem;
      if (exmem.v) begin
        ret_edge[exmem.tag[2:0]] <= edge_n + 1;
        ret_cnt[exmem.tag[2:0]]  <= ret_cnt[exmem.tag[2:0]] + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [4:0] dst, input logic [5:0] op,
                       input logic [4:0] rs, input logic [4:0] rt);
    u_ld = ld; u_dst = dst; u_op = op; u_rs = rs; u_rt = rt;
    #1;
  endtask

  function automatic ins_t mk(input logic ld, input logic [5:0] op, input logic [4:0] rs,
                              input logic [4:0] rt, input int tag);
    ins_t t;
    t.v = 1'b1; t.ld = ld; t.op = op; t.rs = rs; t.rt = rt; t.tag = 4'(tag);
    return t;
  endfunction

  task automatic t_reset_idle;
    unit_mode = 1'b1; u_ctrl = 9'h155;
    drive(1'b0, 5'd0, 6'd0, 5'd0, 5'd0);
    check("R5", {pc_en, dec_en, bubble}, 3'b110, "idle enables");
    check("R6", ex_ctrl, 9'h155, "idle ctrl pass");
  endtask

  task automatic t_rs_match;
    drive(1'b1, 5'd7, 6'd35, 5'd7, 5'd9);
    check("R1", bubble, 1, "rs match load op");
    check("R5", {pc_en, dec_en}, 0, "enables low on hazard");
    drive(1'b1, 5'd7, 6'd2, 5'd7, 5'd0);
    check("R1", bubble, 1, "rs match jump op");
  endtask

  task automatic t_rt_classes;
    drive(1'b1, 5'd9, 6'd0, 5'd1, 5'd9);
    check("R2", bubble, 1, "rt match rformat");
    drive(1'b1, 5'd9, 6'd4, 5'd1, 5'd9);
    check("R2", bubble, 1, "rt match beq");
    drive(1'b1, 5'd9, 6'd5, 5'd1, 5'd9);
    check("R2", bubble, 1, "rt match bne");
    drive(1'b1, 5'd9, 6'd43, 5'd1, 5'd9);
    check("R2", bubble, 1, "rt match store");
    drive(1'b1, 5'd9, 6'd35, 5'd1, 5'd9);
    check("R2", bubble, 0, "rt match load (dest)");
    drive(1'b1, 5'd9, 6'd2, 5'd1, 5'd9);
    check("R2", bubble, 0, "rt match jump");
  endtask

  task automatic t_no_load;
    drive(1'b0, 5'd9, 6'd0, 5'd9, 5'd9);
    check("R3", {pc_en, bubble}, 2'b10, "non-load same regs");
  endtask

  task automatic t_zero_dst;
    drive(1'b1, 5'd0, 6'd0, 5'd0, 5'd0);
    check("R4", bubble, 0, "load to r0");
  endtask

  task automatic t_ctrl_gate;
    u_ctrl = 9'h1FF;
    drive(1'b1, 5'd3, 6'd0, 5'd3, 5'd4);
    check("R6", ex_ctrl, 9'h1E2, "bubble clears bits 0,2,3,4");
    drive(1'b1, 5'd3, 6'd0, 5'd5, 5'd4);
    check("R6", ex_ctrl, 9'h1FF, "no bubble passes all");
  endtask

  task automatic run_prog(input ins_t p0, input ins_t p1, input ins_t p2);
    unit_mode = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) prog[i] = '0;
    prog[0] = p0; prog[1] = p1; prog[2] = p2;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_pipe_dependent;
    run_prog(mk(1, 6'd35, 5'd1, 5'd2, 0), mk(0, 6'd0, 5'd2, 5'd5, 1),
             mk(0, 6'd0, 5'd2, 5'd6, 2));
    check("R7", ret_edge[0], 4, "load retire edge");
    check("R7", ret_edge[1], 6, "dependent retire edge");
    check("R7", ret_edge[2], 7, "follower retire edge");
    check("R7", ret_cnt[1], 1, "held instr retires once");
  endtask

  task automatic t_pipe_independent;
    run_prog(mk(1, 6'd35, 5'd1, 5'd2, 0), mk(0, 6'd0, 5'd3, 5'd5, 1),
             mk(0, 6'd0, 5'd2, 5'd6, 2));
    check("R8", ret_edge[1], 5, "independent retire edge");
    check("R8", ret_edge[2], 6, "distance-two reader retire edge");
    run_prog(mk(1, 6'd35, 5'd1, 5'd2, 0), mk(1, 6'd35, 5'd4, 5'd2, 1),
             mk(0, 6'd0, 5'd0, 5'd0, 2));
    check("R8", ret_edge[2], 6, "load-load same dest no stall");
  endtask

  initial begin
    rst_n = 1'b0;
    unit_mode = 1'b1;
    u_ld = 0; u_dst = 0; u_op = 0; u_rs = 0; u_rt = 0; u_ctrl = 0;
    for (int i = 0; i < 8; i++) prog[i] = '0;
    repeat (2) @(negedge clk);
    t_reset_idle();
    t_rs_match();
    t_rt_classes();
    t_no_load();
    t_zero_dst();
    t_ctrl_gate();
    t_pipe_dependent();
    t_pipe_independent();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule